// File: doc/BRIEF.md
# GPIO Configuration Lock Controller

This block protects the pin configuration of a 16-pin general-purpose I/O port against later change. Software unlocks nothing and arms everything through one register: the lock register. A fixed key sequence written to that register converts its pin-select bits into a per-pin freeze that only a reset clears. While the freeze is active, writes to the configuration fields of the selected pins are dropped, and writes to the fields of all other pins still land.

The controller watches a simple single-cycle register bus (select, write, byte strobes, address, write data, combinational read data). It holds the pin-select bits and the key-state bit and runs the key-sequence state machine. It exports the resulting frozen mask. A small stand-in configuration bank uses that mask. It has a per-pin 2-bit mode field and two registers of 4-bit function-select fields, the low one for pins 0..7 and the high one for pins 8..15. The mask is applied field by field, so one word write can update unlocked pins and skip locked ones.

The key sequence is three full-word writes to the lock register that carry the same pin-select value. Bit 16 is 1 on the first, 0 on the second and 1 on the third. A full-word read of the lock register follows. Any other access to the lock register while the sequence is under way returns the machine to idle. So do a changed pin value, a wrong key bit, a read out of turn, or a partial-word access.

Top module: `cfg_lock_ctrl`

## Requirements
- R1: After reset the lock register reads 0, the frozen mask is 0, the key-state output is 0 and every stand-in configuration register reads 0.
- R2: The lock register sits at offset 0x1C and reads back the pin-select bits in [15:0] and the key-state bit in bit 16. Bits [31:17] always read 0.
- R3: While the key state is 0, any write to the lock register updates the pin-select bytes whose byte strobes are set. Bit 16 changes only through the key sequence.
- R4: A word write with bit16=1, then a word write with bit16=0, then a word write with bit16=1, all with equal [15:0], followed by a word read of the lock register, sets the key state. The frozen mask then equals the pin-select bits from the edge that ends the read onward, and not earlier.
- R5: If the [15:0] value of a later write in the sequence differs from the first, the sequence aborts and the closing read does not lock.
- R6: A lock-register access that is not a full word (byte strobes not 4'b1111) during the sequence aborts it.
- R7: A step out of order aborts the sequence, for example a read before the third write or a repeated bit16=1 write. An aborting write that carries bit16=1 does not start a new sequence.
- R8: Once the key state is 1, it and the pin-select bits stay unchanged until reset, whatever is written to the lock register.
- R9: For a locked pin, writes leave its 2-bit mode field (offset 0x00, pin n at bits 2n+1:2n) and its 4-bit function-select field (offset 0x20 for pins 0..7, offset 0x24 for pins 8..15, pin n at bits 4(n mod 8)+3:4(n mod 8)) unchanged. Unlocked fields take the write wherever their byte strobe is set.
- R10: Reset clears the key state, the pin-select bits and the frozen mask.
- R11: Accesses to offsets other than 0x1C in the middle of the key sequence do not disturb it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_be | input | 4 | Byte strobes; 4'b1111 is a full word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational in the access cycle |
| frozen_mask | output | 16 | One bit per pin; 1 = configuration frozen |
| lock_active | output | 1 | Key state: 1 once a lock has completed |
| cfg_mode | output | 32 | Stand-in mode fields, 2 bits per pin |
| cfg_af_lo | output | 32 | Stand-in function-select fields, pins 0..7 |
| cfg_af_hi | output | 32 | Stand-in function-select fields, pins 8..15 |

## Verification
Read data is combinational, so a read result is due in the access cycle itself. The bench samples it one time unit after driving the access at the falling edge, before the rising edge. Register writes and sequence steps take effect at the rising edge that ends the access, so configuration values, the key state and the frozen mask are sampled only after that edge. The lock check is split on purpose: the read that closes the sequence must still return key state 0, and the key state and mask must be 1 and the pin set right after its edge.

// File: rtl/cfglk_pkg.sv
package cfglk_pkg;

    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;

    localparam logic [7:0] OFS_MODE  = 8'h00;
    localparam logic [7:0] OFS_LOCK  = 8'h1C;
    localparam logic [7:0] OFS_AF_LO = 8'h20;
    localparam logic [7:0] OFS_AF_HI = 8'h24;

    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_ARMED   = 2'd1,
        SEQ_DROPPED = 2'd2,
        SEQ_REARMED = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic              wr;
        logic [BE_W-1:0]   be;
        logic [DATA_W-1:0] data;
    } bus_req_t;

    function automatic logic full_word(input logic [BE_W-1:0] be);
        return &be;
    endfunction

    // Widen a per-pin mask to one bit per register bit for fields of width fw
    // starting at pin base.
    function automatic logic [DATA_W-1:0] spread_mask(input logic [15:0] pins,
                                                      input int fw,
                                                      input int base);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int b = 0; b < DATA_W; b++) begin
            if (base + b / fw < 16) m[b] = pins[base + b / fw];
        end
        return m;
    endfunction

endpackage

// File: rtl/cfglk_seq.sv
module cfglk_seq
    import cfglk_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc,
    input  bus_req_t         req,
    output logic [NPINS-1:0] pins_q,
    output logic             key_q,
    output logic [NPINS-1:0] frozen_o
);
    localparam int KEY_BIT = NPINS;
    localparam int NBYTES  = NPINS / 8;

    seq_state_e st_q, st_d;
    logic       word, key_in, same, lock_now;

    assign word   = full_word(req.be);
    assign key_in = req.data[KEY_BIT];
    assign same   = (req.data[NPINS-1:0] == pins_q);

    always_comb begin
        st_d     = st_q;
        lock_now = 1'b0;
        if (!key_q && acc) begin
            st_d = SEQ_IDLE;
            unique case (st_q)
                SEQ_IDLE:    if (req.wr && word && key_in)          st_d = SEQ_ARMED;
                SEQ_ARMED:   if (req.wr && word && !key_in && same) st_d = SEQ_DROPPED;
                SEQ_DROPPED: if (req.wr && word && key_in && same)  st_d = SEQ_REARMED;
                SEQ_REARMED: if (!req.wr && word)                   lock_now = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SEQ_IDLE;
            pins_q <= '0;
            key_q  <= 1'b0;
        end else begin
            st_q <= st_d;
            if (lock_now) key_q <= 1'b1;
            if (!key_q && acc && req.wr) begin
                for (int k = 0; k < NBYTES; k++) begin
                    if (req.be[k]) pins_q[8*k +: 8] <= req.data[8*k +: 8];
                end
            end
        end
    end

    assign frozen_o = key_q ? pins_q : '0;

endmodule

// File: rtl/cfglk_field_bank.sv
module cfglk_field_bank
    import cfglk_pkg::*;
#(
    parameter int NPINS    = 16,
    parameter int FIELD_W  = 2,
    parameter int PIN_BASE = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BE_W-1:0]   be,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NPINS-1:0]  frozen,
    output logic [DATA_W-1:0] q
);
    localparam int NFIELDS = DATA_W / FIELD_W;

    for (genvar f = 0; f < NFIELDS; f++) begin : g_fld
        localparam int LO   = f * FIELD_W;
        localparam int BYTE = LO / 8;
        localparam int PIN  = PIN_BASE + f;
        logic [FIELD_W-1:0] fq;
        logic               upd;

        assign upd = wr_en && be[BYTE] && !frozen[PIN];

        always_ff @(posedge clk) begin
            if (rst)      fq <= '0;
            else if (upd) fq <= wdata[LO +: FIELD_W];
        end

        assign q[LO +: FIELD_W] = fq;
    end

endmodule

// File: rtl/cfg_lock_ctrl.sv
module cfg_lock_ctrl
    import cfglk_pkg::*;
#(
    parameter int NPINS  = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NPINS-1:0]  frozen_mask,
    output logic              lock_active,
    output logic [DATA_W-1:0] cfg_mode,
    output logic [DATA_W-1:0] cfg_af_lo,
    output logic [DATA_W-1:0] cfg_af_hi
);
    localparam int AF_PINS = DATA_W / 4;

    bus_req_t          req;
    logic              hit_lock, hit_mode, hit_af_lo, hit_af_hi;
    logic [NPINS-1:0]  pins_q;

    assign req       = '{wr: bus_wr, be: bus_be, data: bus_wdata};
    assign hit_lock  = bus_sel && (bus_addr == ADDR_W'(OFS_LOCK));
    assign hit_mode  = bus_sel && (bus_addr == ADDR_W'(OFS_MODE));
    assign hit_af_lo = bus_sel && (bus_addr == ADDR_W'(OFS_AF_LO));
    assign hit_af_hi = bus_sel && (bus_addr == ADDR_W'(OFS_AF_HI));

    cfglk_seq #(.NPINS(NPINS)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .acc      (hit_lock),
        .req      (req),
        .pins_q   (pins_q),
        .key_q    (lock_active),
        .frozen_o (frozen_mask)
    );

    cfglk_field_bank #(.NPINS(NPINS), .FIELD_W(2), .PIN_BASE(0)) u_mode (
        .clk(clk), .rst(rst), .wr_en(hit_mode && bus_wr), .be(bus_be),
        .wdata(bus_wdata), .frozen(frozen_mask), .q(cfg_mode)
    );

    cfglk_field_bank #(.NPINS(NPINS), .FIELD_W(4), .PIN_BASE(0)) u_af_lo (
        .clk(clk), .rst(rst), .wr_en(hit_af_lo && bus_wr), .be(bus_be),
        .wdata(bus_wdata), .frozen(frozen_mask), .q(cfg_af_lo)
    );

    cfglk_field_bank #(.NPINS(NPINS), .FIELD_W(4), .PIN_BASE(AF_PINS)) u_af_hi (
        .clk(clk), .rst(rst), .wr_en(hit_af_hi && bus_wr), .be(bus_be),
        .wdata(bus_wdata), .frozen(frozen_mask), .q(cfg_af_hi)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (hit_lock)       bus_rdata = DATA_W'({lock_active, pins_q});
            else if (hit_mode)  bus_rdata = cfg_mode;
            else if (hit_af_lo) bus_rdata = cfg_af_lo;
            else if (hit_af_hi) bus_rdata = cfg_af_hi;
        end
    end

endmodule

// File: rtl/cfglk_checker.sv
module cfglk_checker
    import cfglk_pkg::*;
#(
    parameter int NPINS  = 16,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BE_W-1:0]   bus_be,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NPINS-1:0]  frozen_mask,
    input logic              lock_active,
    input logic [DATA_W-1:0] cfg_mode
);
    logic [DATA_W-1:0] mode_mask;
    logic              lock_rd;

    assign mode_mask = spread_mask(16'(frozen_mask), 2, 0);
    assign lock_rd   = bus_sel && !bus_wr && (bus_addr == ADDR_W'(OFS_LOCK));

    p_key_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        lock_active |=> lock_active);

    p_mask_hold_r8: assert property (@(posedge clk) disable iff (rst)
        lock_active |=> $stable(frozen_mask));

    p_lock_by_read_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_active) |-> $past(lock_rd && (&bus_be)));

    p_no_mask_unlocked_r4: assert property (@(posedge clk) disable iff (rst)
        !lock_active |-> (frozen_mask == '0));

    p_mode_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        lock_active |=> (((cfg_mode ^ $past(cfg_mode)) & $past(mode_mask)) == '0));

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
        lock_rd |-> (bus_rdata[DATA_W-1:NPINS+1] == '0));

endmodule

bind cfg_lock_ctrl cfglk_checker #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_be      (bus_be),
    .bus_rdata   (bus_rdata),
    .frozen_mask (frozen_mask),
    .lock_active (lock_active),
    .cfg_mode    (cfg_mode)
);

// File: tb/tb_cfg_lock_ctrl.sv
module tb_cfg_lock_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] frozen_mask;
    logic        lock_active;
    logic [31:0] cfg_mode, cfg_af_lo, cfg_af_hi;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    cfg_lock_ctrl dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .frozen_mask(frozen_mask),
        .lock_active(lock_active), .cfg_mode(cfg_mode),
        .cfg_af_lo(cfg_af_lo), .cfg_af_hi(cfg_af_hi)
    );

    // {addr[7:0], be[3:0], wdata[31:0], expected readback[31:0]}
    localparam logic [75:0] VEC [6] = '{
        {8'h00, 4'hF, 32'hA5A5_3C3C, 32'hA5A5_3C3C},
        {8'h00, 4'h1, 32'hFFFF_FF11, 32'hA5A5_3C11},
        {8'h20, 4'hF, 32'h7654_3210, 32'h7654_3210},
        {8'h24, 4'hC, 32'hFEDC_BA98, 32'hFEDC_0000},
        {8'h1C, 4'h3, 32'hFFFF_1234, 32'h0000_1234},
        {8'h1C, 4'hF, 32'hABCC_0000, 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [3:0] be, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_be = be;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        do_reset();

        // R1 reset state
        rd(8'h1C, 4'hF, d); chk("R1 lock reg", d, 32'h0);
        chk("R1 frozen", {16'h0, frozen_mask}, 32'h0);
        chk("R1 key", {31'h0, lock_active}, 32'h0);
        rd(8'h00, 4'hF, d); chk("R1 mode", d, 32'h0);

        // Table: unlocked writes and read-back (R3, R9 byte strobes, R2)
        for (int i = 0; i < 6; i++) begin
            wr(VEC[i][75:68], VEC[i][67:64], VEC[i][63:32]);
            rd(VEC[i][75:68], 4'hF, d);
            chk($sformatf("R3/R9 vector %0d", i), d, VEC[i][31:0]);
        end

        // R5: pin value changes mid sequence
        wr(8'h1C, 4'hF, 32'h0001_00F0);
        wr(8'h1C, 4'hF, 32'h0000_00F1);
        wr(8'h1C, 4'hF, 32'h0001_00F1);
        rd(8'h1C, 4'hF, d);
        chk("R5 no lock", {31'h0, lock_active}, 32'h0);
        rd(8'h1C, 4'hF, d); chk("R5 readback", d, 32'h0000_00F1);

        // R6: partial access mid sequence
        wr(8'h1C, 4'hF, 32'h0001_0055);
        wr(8'h1C, 4'h3, 32'h0000_0055);
        wr(8'h1C, 4'hF, 32'h0001_0055);
        rd(8'h1C, 4'hF, d);
        chk("R6 no lock", {31'h0, lock_active}, 32'h0);

        // R7: read out of turn, then repeated key-one writes
        wr(8'h1C, 4'hF, 32'h0001_0066);
        rd(8'h1C, 4'hF, d);
        wr(8'h1C, 4'hF, 32'h0000_0066);
        wr(8'h1C, 4'hF, 32'h0001_0066);
        rd(8'h1C, 4'hF, d);
        chk("R7 early read", {31'h0, lock_active}, 32'h0);
        wr(8'h1C, 4'hF, 32'h0001_0077);
        wr(8'h1C, 4'hF, 32'h0001_0077);
        wr(8'h1C, 4'hF, 32'h0000_0077);
        wr(8'h1C, 4'hF, 32'h0001_0077);
        rd(8'h1C, 4'hF, d);
        chk("R7 repeated key", {31'h0, lock_active}, 32'h0);

        // R4 + R11: full sequence with foreign accesses in between
        wr(8'h1C, 4'hF, 32'h0001_8003);
        wr(8'h00, 4'hF, 32'h0000_0000);
        rd(8'h20, 4'hF, d); chk("R11 foreign read", d, 32'h7654_3210);
        wr(8'h1C, 4'hF, 32'h0000_8003);
        wr(8'h1C, 4'hF, 32'h0001_8003);
        chk("R4 not before read", {31'h0, lock_active}, 32'h0);
        rd(8'h1C, 4'hF, d);
        chk("R4 read returns key 0", d, 32'h0000_8003);
        chk("R4 key set", {31'h0, lock_active}, 32'h1);
        chk("R4 mask", {16'h0, frozen_mask}, 32'h0000_8003);
        rd(8'h1C, 4'hF, d); chk("R2 locked readback", d, 32'h0001_8003);

        // R9: writes to locked fields dropped
        wr(8'h00, 4'hF, 32'hFFFF_FFFF);
        rd(8'h00, 4'hF, d); chk("R9 mode", d, 32'h3FFF_FFF0);
        wr(8'h20, 4'hF, 32'hFFFF_FFFF);
        rd(8'h20, 4'hF, d); chk("R9 af lo", d, 32'hFFFF_FF10);
        wr(8'h24, 4'hF, 32'h0000_0000);
        rd(8'h24, 4'hF, d); chk("R9 af hi", d, 32'hF000_0000);
        wr(8'h24, 4'h2, 32'h1111_5511);
        rd(8'h24, 4'hF, d); chk("R9 af hi strobe", d, 32'hF000_5500);

        // R8: lock register immune once locked
        wr(8'h1C, 4'hF, 32'h0000_0000);
        wr(8'h1C, 4'hF, 32'h0001_FFFF);
        rd(8'h1C, 4'hF, d); chk("R8 lock reg", d, 32'h0001_8003);
        chk("R8 mask", {16'h0, frozen_mask}, 32'h0000_8003);

        // R10: reset clears the lock
        do_reset();
        rd(8'h1C, 4'hF, d); chk("R10 lock reg", d, 32'h0);
        chk("R10 mask", {16'h0, frozen_mask}, 32'h0);
        chk("R10 key", {31'h0, lock_active}, 32'h0);
        wr(8'h00, 4'hF, 32'h0000_000F);
        rd(8'h00, 4'hF, d); chk("R10 mode writable", d, 32'h0000_000F);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule